// File: doc/BRIEF.md
# Pin Function Multiplexer for a 16-Pin Bank

This block controls a bank of I/O pins, one control slice per pin. Software reaches it through a small register bus (write strobe, byte address, write data, combinational read data). Each register is one bit per pin. For every pin, software picks one of two owners: a plain software-driven port or an on-chip peripheral. It also sets the pin's direction, its pull-up, an analog mode and the value to drive.

When a pin belongs to the peripheral, the peripheral's drive value and drive enable go straight to the pad, and the direction setting has no effect. When a pin is in analog mode, the digital side lets go of it. The pad driver is turned off, and the digital input seen by software and by the peripheral reads 0.

Pad inputs are first resynchronized to the block clock. The result is then offered both as a readable register and as the peripheral's input.

Top module: `pin_mux_bank`

## Requirements
- R1: After reset, the owner register equals parameter `FUNC_RST` (default 0x000F, the debug and clock pins handed to the peripheral), and the direction, pull-up, output and analog registers are all 0, so every other pin is a software-owned input.
- R2: A write with `bus_we` high stores `bus_wdata` into the register at `bus_addr`, and the new value reads back from the next cycle on. The register offsets are: 0x00 owner (bit 1 = peripheral, 0 = software), 0x04 pull-up, 0x08 direction (1 = output), 0x10 output value, 0x14 analog.
- R3: Offset 0x0C returns the synchronized input and cannot be written; a write there changes no register. Any other offset reads 0.
- R4: For a software-owned pin that is not analog, `pad_oe` equals its direction bit and `pad_out` equals its output-value bit.
- R5: For a peripheral-owned pin, `pad_out` follows `per_out`, and `pad_oe` follows `per_oe` unless analog is set; the direction bit has no effect.
- R6: `pad_pu` equals the pull-up register bit for bit.
- R7: While a pin's analog bit is 1, its `pad_oe` is 0, and its bit in both the offset 0x0C read and `per_in` is 0.
- R8: A pad input level becomes visible at 0x0C and on `per_in` after exactly two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| per_out | input | 16 | Peripheral drive values |
| per_oe | input | 16 | Peripheral drive enables |
| per_in | output | 16 | Synchronized pad input to the peripheral |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad driver enables |
| pad_pu | output | 16 | Pad pull-up enables |

## Verification
Random register contents are mixed with random peripheral and pad values. Because of this, the owner, direction and analog bits take all their combinations on different pins in the same cycle. That separates a mux that selects the wrong source from a gate that fails to mask.

Writes also go to the read-only offset and to unused offsets, which shows whether a decode aliases onto a real register. Directed steps hold a pad change for exactly one edge to tell a two-stage synchronizer from a one-stage one. Other directed steps set every bit of the analog and owner registers at once to expose override-ordering errors.

// File: rtl/pin_mux_bank.sv
module pin_mux_bank #(
  parameter int NPINS = 16,
  parameter int AW = 5,
  parameter logic [NPINS-1:0] FUNC_RST = 'h000F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  output logic [NPINS-1:0] per_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu
);
  localparam logic [AW-1:0] OFS_FUNC = AW'(5'h00);
  localparam logic [AW-1:0] OFS_PU   = AW'(5'h04);
  localparam logic [AW-1:0] OFS_DIR  = AW'(5'h08);
  localparam logic [AW-1:0] OFS_IN   = AW'(5'h0C);
  localparam logic [AW-1:0] OFS_OUT  = AW'(5'h10);
  localparam logic [AW-1:0] OFS_ANA  = AW'(5'h14);

  logic [NPINS-1:0] func_q, pu_q, dir_q, out_q, ana_q;
  logic [NPINS-1:0] sy1_q, sy2_q;
  logic [NPINS-1:0] din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= FUNC_RST;
      pu_q   <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      ana_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_FUNC: func_q <= bus_wdata;
        OFS_PU:   pu_q   <= bus_wdata;
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_OUT:  out_q  <= bus_wdata;
        OFS_ANA:  ana_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= pad_in;
      sy2_q <= sy1_q;
    end
  end

  assign din    = sy2_q & ~ana_q;
  assign per_in = din;
  assign pad_pu = pu_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_out[i] = func_q[i] ? per_out[i] : out_q[i];
    assign pad_oe[i]  = !ana_q[i] && (func_q[i] ? per_oe[i] : dir_q[i]);
  end

  always_comb begin
    case (bus_addr)
      OFS_FUNC: bus_rdata = func_q;
      OFS_PU:   bus_rdata = pu_q;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_IN:   bus_rdata = din;
      OFS_OUT:  bus_rdata = out_q;
      OFS_ANA:  bus_rdata = ana_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_mux_bank_chk.sv
module pin_mux_bank_chk #(
  parameter int NPINS = 16,
  parameter int AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] per_oe,
  input logic [NPINS-1:0] per_in,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] func_q,
  input logic [NPINS-1:0] ana_q,
  input logic [NPINS-1:0] out_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_analog_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ana_q) == '0);

  assert_periph_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ per_oe) & func_q & ~ana_q) == '0);

  assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(5'h10)) |=> out_q == $past(bus_wdata));

  assert_pullup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(5'h04)) |=> $stable(pad_pu));

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> per_in == ($past(pad_in, 2) & ~ana_q));
endmodule

bind pin_mux_bank pin_mux_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .per_oe(per_oe), .per_in(per_in), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .func_q(func_q), .ana_q(ana_q), .out_q(out_q)
);

// File: tb/sim_pin_mux_bank.sv
`timescale 1ns/10ps
module sim_pin_mux_bank;
  localparam int N = 16;
  localparam int AW = 5;
  localparam logic [N-1:0] FRST = 16'h000F;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, per_out = '0, per_oe = '0, pad_in = '0;
  logic [N-1:0] bus_rdata, per_in, pad_out, pad_oe, pad_pu;

  int total = 0, bad = 0;
  bit done = 0;
  logic [N-1:0] m_func, m_pu, m_dir, m_out, m_ana, m_s1, m_s2;

  always #4 clk = ~clk;

  pin_mux_bank #(.NPINS(N), .AW(AW), .FUNC_RST(FRST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_out(per_out),
    .per_oe(per_oe), .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu));

  function automatic logic [N-1:0] exp_rd(logic [AW-1:0] a);
    case (a)
      5'h00: return m_func;
      5'h04: return m_pu;
      5'h08: return m_dir;
      5'h0C: return m_s2 & ~m_ana;
      5'h10: return m_out;
      5'h14: return m_ana;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_oe();
    return ~m_ana & ((m_func & per_oe) | (~m_func & m_dir));
  endfunction

  function automatic logic [N-1:0] exp_out();
    return (m_func & per_out) | (~m_func & m_out);
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    bus_we = 0;
    chk("R4/R5 pad_oe", pad_oe, exp_oe());
    chk("R4/R5 pad_out", pad_out, exp_out());
    chk("R6 pad_pu", pad_pu, m_pu);
    chk("R7/R8 per_in", per_in, m_s2 & ~m_ana);
    for (int a = 0; a < 8; a++) begin
      bus_addr = AW'(a * 4);
      #0.1;
      chk("R2/R3 readback", bus_rdata, exp_rd(bus_addr));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (bus_we)
      case (bus_addr)
        5'h00: m_func = bus_wdata;
        5'h04: m_pu = bus_wdata;
        5'h08: m_dir = bus_wdata;
        5'h10: m_out = bus_wdata;
        5'h14: m_ana = bus_wdata;
        default: ;
      endcase
    m_s2 = m_s1;
    m_s1 = pad_in;
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    m_func = FRST; m_pu = '0; m_dir = '0; m_out = '0; m_ana = '0;
    m_s1 = '0; m_s2 = '0;
    chk("R1 reset pad_oe", pad_oe, '0);
    chk("R1 reset pad_pu", pad_pu, '0);
    for (int a = 0; a < 8; a++) begin
      bus_addr = AW'(a * 4);
      #0.1;
      chk("R1 reset readback", bus_rdata, exp_rd(bus_addr));
    end
    rst_n = 1;
    cyc();
    check_all();

    wr(5'h08, 16'hA5A5); wr(5'h10, 16'h3C3C); check_all();
    wr(5'h00, 16'h0000); check_all();
    wr(5'h0C, 16'hFFFF); check_all();
    chk("R3 read-only offset", exp_rd(5'h0C), m_s2 & ~m_ana);
    wr(5'h18, 16'hFFFF); wr(5'h1C, 16'h1234); check_all();

    per_oe = 16'h00FF; per_out = 16'hF0F0;
    wr(5'h00, 16'hFFFF); check_all();
    wr(5'h08, 16'h0000); check_all();
    wr(5'h04, 16'h8001); check_all();

    pad_in = 16'hFFFF;
    wr(5'h14, 16'hFFFF); check_all();
    cyc(); check_all();
    chk("R7 analog per_in", per_in, '0);
    chk("R7 analog pad_oe", pad_oe, '0);
    wr(5'h14, 16'h0000); check_all();
    chk("R8 level seen after sync", per_in, 16'hFFFF);

    pad_in = 16'h1234;
    cyc();
    check_all();
    chk("R8 not after one edge", per_in, 16'hFFFF);
    cyc();
    check_all();
    chk("R8 after two edges", per_in, 16'h1234);

    for (int i = 0; i < 600; i++) begin
      per_out = N'($urandom);
      per_oe  = N'($urandom);
      if ($urandom % 2) pad_in = N'($urandom);
      bus_we    = ($urandom % 3) != 0;
      bus_addr  = AW'(($urandom % 8) * 4);
      bus_wdata = N'($urandom);
      cyc();
      check_all();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule